// File: doc/BRIEF.md
# Sample-Period Interval Timer

This block divides a stream of sample-period tick pulses by a programmable amount and emits a one-clock event each time the programmed number of ticks has elapsed. The interrupt controller uses this event to set its interval-timer pending flag. Software programs the interval through a 16-bit write port. Only the low 10 bits carry the interval. The programmed value reads back on a dedicated output.

The count runs down and is reloaded from the programmed interval only when it reaches its terminal point. A newly written interval therefore takes effect only after the interval already in progress has finished, which can take up to 1024 sample periods. A programmed value of zero selects the longest interval, 1024 periods. When the enable input is low, the counter keeps reloading the current interval and no events are produced, so each enable starts a fresh, complete interval.

Top module: `sample_interval_timer`

## Requirements
- R1: After reset, `rateRd` reads 0, `tcPulse` is low, and the interval is 1024 ticks.
- R2: The interval is taken from `regWrData[9:0]` on a cycle with `regWrEn` high. For a value N from 5 to 1023, `tcPulse` fires on every N-th tick, and the gap between consecutive events stays N ticks.
- R3: A programmed value of 0 gives an interval of 1024 ticks.
- R4: Programmed values 1 to 4 give intervals of exactly that many ticks. A value of 1 fires on every tick.
- R5: `tcPulse` is high for exactly one clock: the cycle after the clock edge that sampled the tick completing the interval.
- R6: A write made while an interval is in progress does not change that interval. The new value is used from the next reload. If a write and a terminal count fall on the same edge, the reload uses the value held before the write.
- R7: While `timerEn` is low, no event is produced and the counter reloads the current interval on every clock. The first event after enabling comes after a full interval.
- R8: `regWrData[15:10]` are ignored, and `rateRd[15:10]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-clock pulse per sample period |
| regWrEn | input | 1 | Write strobe for the interval register |
| regWrData | input | 16 | Write data; bits 9:0 are the interval |
| timerEn | input | 1 | Interval-timer enable |
| rateRd | output | 16 | Programmed interval, upper bits zero |
| tcPulse | output | 1 | Terminal-count event to the interrupt controller |

## Verification
Writes appear on `rateRd` one clock after the write edge. A disabled counter picks up the new value one clock after that. `tcPulse` is registered, so it is high in the cycle after the edge that sampled the completing tick and low again one clock later. The bench drives every input on the falling edge and spaces ticks with an idle cycle. It samples `tcPulse` on the falling edge right after each tick's rising edge, and counts ticks until the event. Interval lengths are therefore compared as tick counts, and a pulse arriving a tick early or late shows up as a wrong count.

// File: rtl/sit_pkg.sv
package sit_pkg;
  localparam int RATE_W = 10;
  localparam int REG_W  = 16;
  localparam int CNT_W  = RATE_W + 1;
  localparam logic [CNT_W-1:0] MAX_SPAN = CNT_W'(1) << RATE_W;

  typedef struct packed {
    logic reload;
    logic step;
  } sitStrobes_t;
endpackage

// File: rtl/sit_datapath.sv
module sit_datapath
  import sit_pkg::*;
#(
  parameter int RW = RATE_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  sitStrobes_t   strobes,
  output logic          atTerm,
  output logic [DW-1:0] rateRd
);
  localparam int CW = RW + 1;
  localparam logic [CW-1:0] SPAN_MAX = CW'(1) << RW;

  logic [RW-1:0] rateReg;
  logic [CW-1:0] remain;
  logic [CW-1:0] spanOfRate;

  assign spanOfRate = (rateReg == '0) ? SPAN_MAX : {1'b0, rateReg};
  assign atTerm = (remain == CW'(1));
  assign rateRd = {{(DW-RW){1'b0}}, rateReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg <= '0;
    end else if (regWrEn) begin
      rateReg <= regWrData[RW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= SPAN_MAX;
    end else if (strobes.reload) begin
      remain <= spanOfRate;
    end else if (strobes.step) begin
      remain <= remain - CW'(1);
    end
  end

  // R2/R3: count never leaves 1..1024
  assert_remain_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (remain != '0) && (remain <= SPAN_MAX));

  // R8: written value returns, upper bits dropped
  assert_write_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> rateRd == {{(DW-RW){1'b0}}, $past(regWrData[RW-1:0])});

  // R6: a reload takes the value held before that edge
  assert_reload_old_rate_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> remain == (($past(rateReg) == '0) ? SPAN_MAX : {1'b0, $past(rateReg)}));
endmodule

// File: rtl/sit_control.sv
module sit_control
  import sit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        timerEn,
  input  logic        atTerm,
  output sitStrobes_t strobes,
  output logic        tcPulse
);
  logic fire;

  assign fire = timerEn && sampleTick && atTerm;

  always_comb begin
    strobes.reload = !timerEn || fire;
    strobes.step   = timerEn && sampleTick && !atTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tcPulse <= 1'b0;
    else       tcPulse <= fire;
  end

  // R5: an event is always caused by an enabled tick on the previous edge
  assert_pulse_has_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> $past(sampleTick && timerEn));

  // R7: disabled means no event next cycle
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> !tcPulse);

  // R5: never two events back to back without a tick completing each
  assert_single_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse && !sampleTick) |=> !tcPulse);
endmodule

// File: rtl/sample_interval_timer.sv
module sample_interval_timer
  import sit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  input  logic        timerEn,
  output logic [15:0] rateRd,
  output logic        tcPulse
);
  sitStrobes_t strobes;
  logic        atTerm;

  sit_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .timerEn    (timerEn),
    .atTerm     (atTerm),
    .strobes    (strobes),
    .tcPulse    (tcPulse)
  );

  sit_datapath #(.RW(RATE_W), .DW(REG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobes   (strobes),
    .atTerm    (atTerm),
    .rateRd    (rateRd)
  );
endmodule

// File: tb/tb_sample_interval_timer.sv
module tb_sample_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {programmed value, expected ticks per interval}
  localparam int VEC_RATE [NVEC] = '{0, 1, 2, 4, 5, 100, 1023};
  localparam int VEC_SPAN [NVEC] = '{1024, 1, 2, 4, 5, 100, 1023};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic timerEn = 1'b0;
  logic [15:0] rateRd;
  logic tcPulse;
  int nRun = 0;
  int nFail = 0;

  sample_interval_timer dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .regWrEn(regWrEn),
    .regWrData(regWrData), .timerEn(timerEn), .rateRd(rateRd), .tcPulse(tcPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeRate(input logic [15:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic tickOnce(output logic got);
    @(negedge clk); sampleTick = 1'b1;
    @(negedge clk); sampleTick = 1'b0; got = tcPulse;
  endtask

  task automatic measure(output int n);
    logic got;
    n = 0;
    got = 1'b0;
    while (!got && n < 2000) begin
      tickOnce(got);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int n;
    logic got;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rateRd", int'(rateRd), 0);
    check("R1 tcPulse", int'(tcPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    timerEn = 1'b1;
    measure(n);
    check("R1 default interval", n, 1024);
    timerEn = 1'b0;

    // R2 R3 R4: table walk, two consecutive intervals each
    for (int i = 0; i < NVEC; i++) begin
      timerEn = 1'b0;
      writeRate(16'(VEC_RATE[i]));
      timerEn = 1'b1;
      measure(n);
      check(VEC_RATE[i] == 0 ? "R3 first" : (VEC_RATE[i] < 5 ? "R4 first" : "R2 first"), n, VEC_SPAN[i]);
      measure(n);
      check(VEC_RATE[i] == 0 ? "R3 repeat" : (VEC_RATE[i] < 5 ? "R4 repeat" : "R2 repeat"), n, VEC_SPAN[i]);
    end

    // R5: pulse one clock wide
    timerEn = 1'b0;
    writeRate(16'd3);
    timerEn = 1'b1;
    measure(n);
    @(negedge clk);
    check("R5 pulse width", int'(tcPulse), 0);

    // R6: write mid-interval is deferred
    timerEn = 1'b0;
    writeRate(16'd10);
    timerEn = 1'b1;
    for (int k = 0; k < 3; k++) tickOnce(got);
    writeRate(16'd4);
    measure(n);
    check("R6 old interval finishes", n, 7);
    measure(n);
    check("R6 new interval applied", n, 4);

    // R7: disabled gives no event, then full interval on enable
    timerEn = 1'b1;
    tickOnce(got);
    tickOnce(got);
    timerEn = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tickOnce(got);
      n += int'(got);
    end
    check("R7 no events while off", n, 0);
    timerEn = 1'b1;
    measure(n);
    check("R7 full interval after enable", n, 4);

    // R8: upper bits ignored
    timerEn = 1'b0;
    writeRate(16'hFC07);
    check("R8 readback", int'(rateRd), 7);
    timerEn = 1'b1;
    measure(n);
    check("R8 interval uses low bits", n, 7);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule